// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that holds 1024 words of 18 bits between two unrelated clock domains. Words enter on the write clock while `wr_en` is high and `cfg_n` is high. They leave on the read clock while `rd_en` is high. The word taken by a read lands in a registered output, and `out_en` gates that output onto `q`. Each domain owns its own binary pointer and passes a Gray-coded copy of it to the other domain through a two-flop synchroniser. `full` and `half` are derived in the write domain, and `empty` is derived in the read domain.

Two threshold registers set where `almost_empty` and `almost_full` switch. They are written through `din` while `cfg_n` is low and `wr_en` is high. A two-state sequencer picks the target register. State `LOAD_AE_OFS` writes the empty threshold and moves to `LOAD_AF_OFS` (transition *ae_loaded*). State `LOAD_AF_OFS` writes the full threshold and moves back to `LOAD_AE_OFS` (transition *af_loaded*). Reset puts the sequencer in `LOAD_AE_OFS` and loads both thresholds with 127.

`flag_reg_mode` sets how the two threshold flags are produced. When it is low they follow the word count directly. When it is high each one passes through a register in its own domain. A `rewind` pulse on the read clock sends reading back to location 0 and leaves the write side alone, so the stored words can be read out again.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low, `q` reads 0 (with `out_en` high), `empty` and `almost_empty` are 1, `full`, `half` and `almost_full` are 0, and both pointers return to location 0.
- R2: Words leave in the order they were written. A read accepted at a read-clock edge (`rd_en`=1, `empty`=0) shows its word on `q` right after that edge. Without an accepted read, `q` holds its value.
- R3: `full` is 1 exactly when 1024 words are held. A write attempted while `full` is 1 changes no stored word and no pointer.
- R4: `empty` is 1 exactly when no word is held. A read attempted while `empty` is 1 leaves `q` and the read pointer unchanged.
- R5: The control pair decodes as follows. `cfg_n`=0 with `wr_en`=1 loads a threshold register and stores no data. `cfg_n`=0 with `wr_en`=0 does nothing. `cfg_n`=1 with `wr_en`=1 stores `din` as data.
- R6: Threshold loads alternate between the two registers. The first load after reset goes to the empty threshold, the next to the full threshold, and so on. The value is taken from `din[9:0]`, and the upper bits are ignored.
- R7: After reset both thresholds are 127.
- R8: `almost_empty` is 1 when the word count is at or below the empty threshold.
- R9: `almost_full` is 1 when the word count is at or above 1024 minus the full threshold.
- R10: `half` is 1 when the word count is 513 or more, and 0 when it is 512 or less.
- R11: With `flag_reg_mode`=0, `almost_empty` and `almost_full` change right after the own-domain edge that moves the count across the threshold. With `flag_reg_mode`=1 they change one edge later: `almost_empty` on the read clock and `almost_full` on the write clock.
- R12: A `rewind` pulse sets the read pointer to location 0 and leaves the write pointer unchanged. Once the pointers have crossed the domains again, the words from location 0 onward are read again, followed by any words written later.
- R13: `q` carries the output register when `out_en` is 1 and reads 0 when `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en | input | 1 | Write strobe (data or threshold, per `cfg_n`) |
| cfg_n | input | 1 | Low selects a threshold load instead of a data write |
| din | input | 18 | Write data, or a threshold value in bits 9:0 |
| rd_en | input | 1 | Read strobe |
| rewind | input | 1 | Restart reading at location 0 |
| out_en | input | 1 | Gates the output register onto `q` |
| flag_reg_mode | input | 1 | 1 registers the threshold flags in their own domains |
| q | output | 18 | Read data |
| full | output | 1 | 1024 words held (write domain) |
| empty | output | 1 | No word held (read domain) |
| half | output | 1 | More than 512 words held (write domain) |
| almost_empty | output | 1 | Count at or below the empty threshold (read domain) |
| almost_full | output | 1 | Count at or above 1024 minus the full threshold (write domain) |

## Verification
Some results appear right after the edge that causes them. The read data and the own-domain flags change after the accepted edge: `full` after a write, and `empty`/`almost_empty` after a read. A registered threshold flag follows one own-domain edge later. A change made in the opposite domain needs a Gray register plus two synchroniser flops, about three edges of the observing clock, to show up. The bench therefore checks `q` one time unit after the read edge. It checks the same-domain threshold flags in the first and second edge after a directed crossing. It compares every flag against the expected count only after at least eight cycles of both clocks with no traffic.

// File: rtl/pflag_fifo_pkg.sv
`timescale 1ns/1ps
package pflag_fifo_pkg;

    // Target of the next threshold load.
    typedef enum logic {
        LOAD_AE_OFS = 1'b0,
        LOAD_AF_OFS = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/pflag_fifo_sync.sv
`timescale 1ns/1ps
module pflag_fifo_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pflag_fifo_mem.sv
`timescale 1ns/1ps
module pflag_fifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Output register: cleared by reset, loaded only by an accepted read.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/pflag_fifo_wside.sv
`timescale 1ns/1ps
module pflag_fifo_wside
    import pflag_fifo_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 10,
    parameter int OFS_DEFAULT = 127
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cfg_n,
    input  logic [DATA_W-1:0] din,
    input  logic              reg_mode,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic              full,
    output logic              half,
    output logic              almost_full,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs,
    output ofs_sel_e          ld_state
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0]     DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0]     HALF_UP = PW'(DEPTH / 2 + 1);
    localparam logic [ADDR_W-1:0] OFS_RST = ADDR_W'(OFS_DEFAULT);

    ofs_sel_e      ld_next;
    logic          ofs_wr;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wbin_nx;
    logic          af_now;
    logic          af_q;

    // Gray to binary for the synchronised read pointer.
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
    end

    assign wcount      = wbin - rbin_s;
    assign full        = (wcount == DEPTH_P);
    assign half        = (wcount >= HALF_UP);
    assign af_now      = (wcount >= (DEPTH_P - {1'b0, af_ofs}));
    assign almost_full = reg_mode ? af_q : af_now;
    assign mem_we      = wr_en && cfg_n && !full;
    assign ofs_wr      = wr_en && !cfg_n;
    assign wbin_nx     = wbin + PW'(1);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            af_q  <= 1'b0;
        end else begin
            if (mem_we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            af_q <= af_now;
        end
    end

    // Threshold load sequencer: state register.
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) ld_state <= LOAD_AE_OFS;
        else        ld_state <= ld_next;
    end

    // Next state: ae_loaded / af_loaded transitions.
    always_comb begin
        ld_next = ld_state;
        if (ofs_wr) begin
            unique case (ld_state)
                LOAD_AE_OFS: ld_next = LOAD_AF_OFS;
                LOAD_AF_OFS: ld_next = LOAD_AE_OFS;
            endcase
        end
    end

    // Sequencer outputs: the threshold registers.
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OFS_RST;
            af_ofs <= OFS_RST;
        end else if (ofs_wr) begin
            unique case (ld_state)
                LOAD_AE_OFS: ae_ofs <= din[ADDR_W-1:0];
                LOAD_AF_OFS: af_ofs <= din[ADDR_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pflag_fifo_rside.sv
`timescale 1ns/1ps
module pflag_fifo_rside #(
    parameter int ADDR_W = 10
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              reg_mode,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              mem_re,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rbin_nx;
    logic          ae_now;
    logic          ae_q;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync >> i);
    end

    assign rcount       = wbin_s - rbin;
    assign empty        = (rcount == '0);
    assign ae_now       = (rcount <= {1'b0, ae_ofs});
    assign almost_empty = reg_mode ? ae_q : ae_now;
    assign mem_re       = rd_en && !empty && !rewind;
    assign rbin_nx      = rbin + PW'(1);

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            ae_q  <= 1'b1;
        end else begin
            if (rewind) begin
                rbin  <= '0;
                rgray <= '0;
            end else if (mem_re) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
            ae_q <= ae_now;
        end
    end
endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 10,
    parameter int OFS_DEFAULT = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cfg_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              out_en,
    input  logic              flag_reg_mode,
    output logic [DATA_W-1:0] q,
    output logic              full,
    output logic              empty,
    output logic              half,
    output logic              almost_empty,
    output logic              almost_full
);
    logic [ADDR_W:0]   wr_bin, wr_gray, rd_bin, rd_gray;
    logic [ADDR_W:0]   wgray_rs, rgray_ws;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] ae_ofs, af_ofs;
    logic [DATA_W-1:0] q_reg;
    ofs_sel_e          ld_state;

    pflag_fifo_wside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_DEFAULT(OFS_DEFAULT)) u_wside (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_n(cfg_n), .din(din),
        .reg_mode(flag_reg_mode), .rgray_sync(rgray_ws), .wbin(wr_bin), .wgray(wr_gray),
        .mem_we(mem_we), .full(full), .half(half), .almost_full(almost_full),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ld_state(ld_state)
    );

    pflag_fifo_rside #(.ADDR_W(ADDR_W)) u_rside (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .rewind(rewind),
        .reg_mode(flag_reg_mode), .wgray_sync(wgray_rs), .ae_ofs(ae_ofs),
        .rbin(rd_bin), .rgray(rd_gray), .mem_re(mem_re), .empty(empty),
        .almost_empty(almost_empty)
    );

    pflag_fifo_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wgray_rs)
    );

    pflag_fifo_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rgray_ws)
    );

    pflag_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(wr_bin[ADDR_W-1:0]), .wdata(din),
        .rclk(rclk), .rst_n(rst_n), .re(mem_re), .raddr(rd_bin[ADDR_W-1:0]),
        .rdata(q_reg)
    );

    assign q = out_en ? q_reg : '0;
endmodule

// File: rtl/pflag_fifo_chk.sv
`timescale 1ns/1ps
module pflag_fifo_chk
    import pflag_fifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              cfg_n,
    input logic              rd_en,
    input logic              rewind,
    input logic              full,
    input logic              empty,
    input logic              half,
    input logic [ADDR_W:0]   wr_bin,
    input logic [ADDR_W:0]   rd_bin,
    input logic [DATA_W-1:0] q_reg,
    input logic [ADDR_W-1:0] ae_ofs,
    input logic [ADDR_W-1:0] af_ofs,
    input ofs_sel_e          ld_state
);
    always @(posedge wclk) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (wr_bin == '0 && rd_bin == '0 && !full && q_reg == '0
                                      && ld_state == LOAD_AE_OFS)
                else $error("R1 reset state violated");
        end
    end

    a_r3_blocked_write: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wr_en && cfg_n) |=> $stable(wr_bin))
        else $error("R3 write pointer moved while full");

    a_r4_blocked_read: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && rd_en && !rewind) |=> ($stable(rd_bin) && $stable(q_reg)))
        else $error("R4 read state moved while empty");

    a_r5_idle_load: assert property (@(posedge wclk) disable iff (!rst_n)
        (!cfg_n && !wr_en) |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(ld_state)))
        else $error("R5 idle load changed state");

    a_r5_load_no_data: assert property (@(posedge wclk) disable iff (!rst_n)
        (!cfg_n) |=> $stable(wr_bin))
        else $error("R5 threshold load stored data");

    a_r6_load_alternates: assert property (@(posedge wclk) disable iff (!rst_n)
        (!cfg_n && wr_en) |=> (ld_state != $past(ld_state)))
        else $error("R6 load target did not alternate");

    a_r10_full_implies_half: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> half)
        else $error("R10 full without half");

    a_r12_rewind_start: assert property (@(posedge rclk) disable iff (!rst_n)
        rewind |=> (rd_bin == '0))
        else $error("R12 rewind did not restart reading");
endmodule

bind pflag_fifo pflag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_n(cfg_n),
    .rd_en(rd_en), .rewind(rewind), .full(full), .empty(empty), .half(half),
    .wr_bin(wr_bin), .rd_bin(rd_bin), .q_reg(q_reg), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .ld_state(ld_state)
);

// File: tb/pflag_fifo_test.sv
`timescale 1ns/1ps
module pflag_fifo_test;
    localparam int DW    = 18;
    localparam int DEPTH = 1024;

    logic wclk = 1'b0, rclk = 1'b0;
    always #4 wclk = ~wclk;   // 125 MHz
    always #5 rclk = ~rclk;   // 100 MHz

    logic          rst_n = 1'b0, wr_en = 1'b0, cfg_n = 1'b1, rd_en = 1'b0;
    logic          rewind = 1'b0, out_en = 1'b1, flag_reg_mode = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic          full, empty, half, almost_empty, almost_full;

    pflag_fifo uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_n(cfg_n),
        .din(din), .rd_en(rd_en), .rewind(rewind), .out_en(out_en),
        .flag_reg_mode(flag_reg_mode), .q(q), .full(full), .empty(empty),
        .half(half), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    int            n_checks = 0, n_fail = 0;
    int            ae_m = 127, af_m = 127;
    logic [DW-1:0] model [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ae(int n); return n <= ae_m; endfunction
    function automatic bit exp_af(int n); return n >= DEPTH - af_m; endfunction
    function automatic bit exp_half(int n); return n >= DEPTH / 2 + 1; endfunction

    task automatic settle();
        repeat (8) @(posedge rclk);
        @(negedge wclk);
    endtask

    task automatic check_flags(input string where);
        int n = model.size();
        chk({"R3 full ", where},          32'(full),         32'(n == DEPTH));
        chk({"R4 empty ", where},         32'(empty),        32'(n == 0));
        chk({"R10 half ", where},         32'(half),         32'(exp_half(n)));
        chk({"R8 almost_empty ", where},  32'(almost_empty), 32'(exp_ae(n)));
        chk({"R9 almost_full ", where},   32'(almost_full),  32'(exp_af(n)));
    endtask

    task automatic wr_cycle(input bit go, input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = go; cfg_n = 1'b1; din = d;
        if (go && !full) model.push_back(d);
        @(posedge wclk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_cycle(input bit go);
        logic [DW-1:0] prev, e;
        bit acc;
        @(negedge rclk);
        rd_en = go;
        acc = go && !empty;
        prev = q;
        e = '0;
        if (acc) e = model.pop_front();
        @(posedge rclk); #1;
        rd_en = 1'b0;
        if (acc)     chk("R2 read order", 32'(q), 32'(e));
        else if (go) chk("R4 blocked read keeps q", 32'(q), 32'(prev));
        else         chk("R2 q holds without read", 32'(q), 32'(prev));
    endtask

    task automatic write_to(input int target);
        while (model.size() < target) wr_cycle(1'b1, DW'($urandom));
    endtask

    task automatic cfg_cycle(input bit go, input logic [DW-1:0] d);
        @(negedge wclk);
        cfg_n = 1'b0; wr_en = go; din = d;
        @(posedge wclk); #1;
        wr_en = 1'b0; cfg_n = 1'b1;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge wclk);
        rst_n = 1'b0; flag_reg_mode = mode;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0; cfg_n = 1'b1; out_en = 1'b1;
        repeat (3) @(posedge wclk);
        #1;
        model.delete(); ae_m = 127; af_m = 127;
        chk("R1 q low in reset", 32'(q), 32'd0);
        chk("R1 empty in reset", 32'(empty), 32'd1);
        chk("R1 full clear in reset", 32'(full), 32'd0);
        chk("R1 almost_full clear in reset", 32'(almost_full), 32'd0);
        @(negedge wclk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic mix(input int cycles, input int wp, input int rp);
        fork
            begin repeat (cycles) wr_cycle(($urandom % 100) < wp, DW'($urandom)); end
            begin repeat (cycles) rd_cycle(($urandom % 100) < rp); end
        join
    endtask

    task automatic af_step(input bit mode);
        do_reset(mode);
        write_to(DEPTH - 128);
        settle();
        chk("R11 almost_full before step", 32'(almost_full), 32'd0);
        wr_cycle(1'b1, DW'($urandom));
        chk("R11 almost_full first write edge", 32'(almost_full), 32'(!mode));
        @(posedge wclk); #1;
        chk("R11 almost_full second write edge", 32'(almost_full), 32'd1);
    endtask

    task automatic ae_step(input bit mode);
        do_reset(mode);
        write_to(128);
        settle();
        chk("R11 almost_empty before step", 32'(almost_empty), 32'd0);
        rd_cycle(1'b1);
        chk("R11 almost_empty first read edge", 32'(almost_empty), 32'(!mode));
        @(posedge rclk); #1;
        chk("R11 almost_empty second read edge", 32'(almost_empty), 32'd1);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #1_500_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        logic [DW-1:0] saved [$];
        void'($urandom(32'd20240611));

        // R1 reset state, R7 default thresholds
        do_reset(1'b0);
        check_flags("R1 after reset");
        write_to(127);       settle(); check_flags("R7 count 127");
        write_to(128);       settle(); check_flags("R7 count 128");
        write_to(512);       settle(); check_flags("R10 count 512");
        write_to(513);       settle(); check_flags("R10 count 513");
        write_to(896);       settle(); check_flags("R7 count 896");
        write_to(897);       settle(); check_flags("R7 count 897");
        write_to(DEPTH);     settle(); check_flags("R3 count 1024");
        repeat (3) wr_cycle(1'b1, 18'h2AAAA);   // R3 blocked writes
        settle(); check_flags("R3 after blocked writes");
        while (model.size() > 0) rd_cycle(1'b1);
        settle(); check_flags("R4 drained");
        rd_cycle(1'b1);                          // R4 blocked read
        wr_cycle(1'b1, 18'h1234F);
        settle();
        rd_cycle(1'b1);                          // R4 pointer kept its place

        // R5/R6 threshold programming
        cfg_cycle(1'b1, 18'h00004);              // empty threshold
        cfg_cycle(1'b0, 18'h003E7);              // R5 no-op
        cfg_cycle(1'b1, 18'h3F006);              // R6 full threshold, upper bits ignored
        ae_m = 4; af_m = 6;
        settle(); check_flags("R5 no data stored by loads");
        write_to(4);         settle(); check_flags("R8 count 4");
        write_to(5);         settle(); check_flags("R8 count 5");
        write_to(1017);      settle(); check_flags("R9 count 1017");
        write_to(1018);      settle(); check_flags("R6 count 1018");
        while (model.size() > 0) rd_cycle(1'b1);
        settle(); check_flags("R2 drained after programming");

        // R11 flag timing in both modes
        af_step(1'b0); af_step(1'b1);
        ae_step(1'b0); ae_step(1'b1);

        // R12 rewind
        do_reset(1'b0);
        write_to(10);
        saved = model;
        settle();
        repeat (6) rd_cycle(1'b1);
        @(negedge rclk); rewind = 1'b1;
        @(posedge rclk); #1; rewind = 1'b0;
        model = saved;
        wr_cycle(1'b1, 18'h0BEEF);
        settle(); check_flags("R12 after rewind");
        while (model.size() > 0) rd_cycle(1'b1);
        settle(); check_flags("R12 drained");

        // R13 output enable
        wr_cycle(1'b1, 18'h3C3C3);
        settle();
        rd_cycle(1'b1);
        @(negedge wclk); out_en = 1'b0; #1;
        chk("R13 q zero when disabled", 32'(q), 32'd0);
        out_en = 1'b1; #1;
        chk("R13 q restored when enabled", 32'(q), 32'h3C3C3);

        // Random traffic in both flag modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            mix(1500, 95, 20);
            mix(1500, 30, 90);
            settle(); check_flags("R2 random settled");
            while (model.size() > 0) rd_cycle(1'b1);
            settle(); check_flags("R4 random drained");
        end

        report();
        $finish;
    end
endmodule